// File: doc/BRIEF.md
# SPI Frame Sequencer with Automatic Select

This block is the serial engine of an SPI master. It takes words from a transmit FIFO one frame at a time and shifts each one out on MOSI, most significant bit first, in SPI mode 0. It samples MISO on every rising SCLK edge and hands the received frame to a receive FIFO. The FIFO storage lives outside the block. The block sees only an empty flag, a head word and a pop strobe on the transmit side, and a push strobe with data on the receive side.

The select line SS0 is driven by the block itself. A burst length, counted in frames, is loaded on every control write. In hold mode SS0 stays low for the whole burst. In pulse mode SS0 rises after every frame and stays high for at least one SCLK period. When the last frame of a burst completes, four things happen: the count reloads, SS0 goes high, the done and ready status levels are set, and a one-cycle completion event is raised for an interrupt block outside. The frame size is programmable from 1 to 32 bits. The SCLK rate is set by a divider register.

Top module: `spi_frame_seq`

## Requirements
- R1: After reset the engine is disabled and idle. SS0 is high, SCLK is low, no pop occurs and the done/ready status is clear. The frame size is 4, the divider is 7, hold mode is off and the burst count is 1. A control write with `ctrl_soft_reset` high returns the block to this same state and abandons any frame in flight.
- R2: A frame starts only when the engine is enabled, the transmit FIFO is not empty and the remaining burst count is non-zero, and only from idle. In that cycle `tx_pop` is high for exactly one cycle, and SS0 is low from the next cycle.
- R3: SCLK idles low and toggles every 2*(divider+1) system clocks while a frame is active. MOSI carries the low `size` bits of the transmit word, most significant of them first, and changes only after falling SCLK edges. Transmit bits above the frame size have no effect on MOSI.
- R4: MISO is sampled on each rising SCLK edge. On the falling edge that ends the last bit, `rx_push` is high for one cycle. At that point `rx_data` holds the received bits in its low `size` bits, with the first bit received as the most significant of them, and all higher bits zero.
- R5: In hold mode SS0 stays low from the first frame of a burst until the burst's last frame completes, including while waiting for the transmit FIFO.
- R6: In pulse mode SS0 returns high after every frame and stays high for two SCLK half periods before the next frame may start. The same gap also follows the last frame of a burst in either mode.
- R7: When the burst's last frame completes, SS0 goes high, the count reloads from the programmed burst length, `xfer_done` and `rx_ready` go high, and `burst_done` pulses for one cycle.
- R8: `xfer_done` and `rx_ready` clear when a frame starts.
- R9: A frame-size write is ignored if its value exceeds 32 or if the engine is enabled at the time of the write. The number of SCLK rising edges in a frame equals the accepted size.
- R10: Every control write reloads the burst count from `ctrl_frames`. With a count of zero no frame starts, even when enabled with data waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_enable | input | 1 | Engine enable value written |
| ctrl_hold_ss | input | 1 | 1 = hold select across burst, 0 = pulse per frame |
| ctrl_frames | input | 16 | Burst length in frames |
| ctrl_soft_reset | input | 1 | With ctrl_we, resets the whole block |
| fsz_we | input | 1 | Frame-size write strobe |
| fsz_wdata | input | 6 | Frame size in bits (1..32) |
| div_we | input | 1 | Divider write strobe |
| div_wdata | input | DIVW | SCLK divider value |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_data | input | 32 | Transmit FIFO head word |
| tx_pop | output | 1 | Transmit FIFO pop |
| rx_push | output | 1 | Receive FIFO push |
| rx_data | output | 32 | Received frame, zero-extended |
| sclk | output | 1 | SPI clock |
| mosi | output | 1 | SPI data out |
| miso | input | 1 | SPI data in |
| ss0 | output | 1 | Active-low chip select |
| xfer_done | output | 1 | Transfer-done status level |
| rx_ready | output | 1 | Receive-ready status level |
| burst_done | output | 1 | One-cycle burst completion event |

## Verification
A wrong bit counter or divider count shows up at the pins within one SCLK half period. The cause is either an SCLK edge in the wrong system cycle or a frame with the wrong number of rising edges. A wrong burst count or select state shows at SS0 and `burst_done` when the affected frame ends, which comes well before the next pop. A wrong receive shift shows as a wrong `rx_data` word at the push. The bench therefore steps a behavioural model alongside the design and compares every output pin on every clock, so any such divergence is reported in the cycle it appears.

// File: rtl/spi_frame_seq.sv
module spi_frame_seq #(
  parameter int DIVW    = 8,
  parameter int DIV_RST = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ctrl_we,
  input  logic            ctrl_enable,
  input  logic            ctrl_hold_ss,
  input  logic [15:0]     ctrl_frames,
  input  logic            ctrl_soft_reset,
  input  logic            fsz_we,
  input  logic [5:0]      fsz_wdata,
  input  logic            div_we,
  input  logic [DIVW-1:0] div_wdata,
  input  logic            tx_empty,
  input  logic [31:0]     tx_data,
  output logic            tx_pop,
  output logic            rx_push,
  output logic [31:0]     rx_data,
  output logic            sclk,
  output logic            mosi,
  input  logic            miso,
  output logic            ss0,
  output logic            xfer_done,
  output logic            rx_ready,
  output logic            burst_done
);
  localparam int WORD = 32;
  localparam logic [5:0] FSZ_MAX = 6'(WORD);
  localparam logic [5:0] FSZ_RST = 6'd4;

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_GAP} st_t;

  st_t            st_q;
  logic           en_q, hold_q, sclk_q, ss_q, done_q, pulse_q, ph_q;
  logic [15:0]    fld_q, cnt_q;
  logic [5:0]     fsz_q, bits_q;
  logic [DIVW-1:0] div_q;
  logic [DIVW:0]  hc_q;
  logic [WORD-1:0] sh_q, rx_q;

  wire        soft_rst = ctrl_we && ctrl_soft_reset;
  wire [5:0]  nbits    = (fsz_q == 6'd0) ? 6'd1 : fsz_q;
  wire [5:0]  lsh      = FSZ_MAX - nbits;
  wire        tick     = hc_q == {div_q, 1'b1};
  wire        start    = (st_q == S_IDLE) && en_q && !tx_empty && (cnt_q != 16'd0);
  wire        last     = (st_q == S_SHIFT) && tick && sclk_q && (bits_q == 6'd1);
  wire        burst_end = last && (cnt_q == 16'd1);

  assign tx_pop     = start;
  assign rx_push    = last;
  assign rx_data    = rx_q;
  assign sclk       = sclk_q;
  assign mosi       = (st_q == S_SHIFT) && sh_q[WORD-1];
  assign ss0        = ss_q;
  assign xfer_done  = done_q;
  assign rx_ready   = done_q;
  assign burst_done = pulse_q;

  always_ff @(posedge clk) begin
    pulse_q <= 1'b0;
    if (!rst_n || soft_rst) begin
      st_q   <= S_IDLE;
      en_q   <= 1'b0;
      hold_q <= 1'b0;
      fld_q  <= 16'd1;
      cnt_q  <= 16'd1;
      fsz_q  <= FSZ_RST;
      div_q  <= DIVW'(DIV_RST);
      hc_q   <= '0;
      ph_q   <= 1'b0;
      sclk_q <= 1'b0;
      ss_q   <= 1'b1;
      done_q <= 1'b0;
      bits_q <= '0;
      sh_q   <= '0;
      rx_q   <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (start) begin
          st_q   <= S_SHIFT;
          sh_q   <= tx_data << lsh;
          rx_q   <= '0;
          bits_q <= nbits;
          hc_q   <= '0;
          sclk_q <= 1'b0;
          ss_q   <= 1'b0;
          done_q <= 1'b0;
        end
        S_SHIFT: begin
          hc_q <= tick ? '0 : hc_q + 1'b1;
          if (tick) begin
            sclk_q <= ~sclk_q;
            if (!sclk_q) begin
              rx_q <= {rx_q[WORD-2:0], miso};
            end else begin
              sh_q   <= sh_q << 1;
              bits_q <= bits_q - 6'd1;
              if (last) begin
                ph_q <= 1'b0;
                if (burst_end) begin
                  cnt_q   <= fld_q;
                  ss_q    <= 1'b1;
                  done_q  <= 1'b1;
                  pulse_q <= 1'b1;
                  st_q    <= S_GAP;
                end else begin
                  cnt_q <= cnt_q - 16'd1;
                  if (hold_q) begin
                    st_q <= S_IDLE;
                  end else begin
                    ss_q <= 1'b1;
                    st_q <= S_GAP;
                  end
                end
              end
            end
          end
        end
        S_GAP: begin
          hc_q <= tick ? '0 : hc_q + 1'b1;
          if (tick) begin
            ph_q <= ~ph_q;
            if (ph_q) st_q <= S_IDLE;
          end
        end
        default: st_q <= S_IDLE;
      endcase
      if (fsz_we && !en_q && fsz_wdata <= FSZ_MAX) fsz_q <= fsz_wdata;
      if (div_we) div_q <= div_wdata;
      if (ctrl_we) begin
        en_q   <= ctrl_enable;
        hold_q <= ctrl_hold_ss;
        fld_q  <= ctrl_frames;
        cnt_q  <= ctrl_frames;
      end
    end
  end

  assert_pop_selects_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_pop && !soft_rst) |=> !ss0)
    else $error("R2: select not low after pop");

  assert_idle_clock_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ss0 |-> !sclk)
    else $error("R3: SCLK high while deselected");

  assert_push_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |=> !rx_push)
    else $error("R4: push longer than one cycle");

  assert_burst_deselects_R7: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |-> (ss0 && xfer_done))
    else $error("R7: completion without deselect and done");

  assert_done_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_pop && !soft_rst) |=> !xfer_done)
    else $error("R8: done not cleared at frame start");

  assert_fsz_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fsz_q <= FSZ_MAX)
    else $error("R9: frame size above limit");
endmodule

// File: tb/tb_spi_frame_seq.sv
`timescale 1ns/1ps
module tb_spi_frame_seq;
  localparam int DIVW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctrl_we = 0, ctrl_enable = 0, ctrl_hold_ss = 0, ctrl_soft_reset = 0;
  logic [15:0] ctrl_frames = '0;
  logic fsz_we = 0;
  logic [5:0] fsz_wdata = '0;
  logic div_we = 0;
  logic [DIVW-1:0] div_wdata = '0;
  logic tx_empty = 1'b1;
  logic [31:0] tx_data = '0;
  logic miso = 1'b0;
  logic tx_pop, rx_push, sclk, mosi, ss0, xfer_done, rx_ready, burst_done;
  logic [31:0] rx_data;

  spi_frame_seq #(.DIVW(DIVW), .DIV_RST(7)) dut (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_enable(ctrl_enable),
    .ctrl_hold_ss(ctrl_hold_ss), .ctrl_frames(ctrl_frames),
    .ctrl_soft_reset(ctrl_soft_reset), .fsz_we(fsz_we), .fsz_wdata(fsz_wdata),
    .div_we(div_we), .div_wdata(div_wdata), .tx_empty(tx_empty),
    .tx_data(tx_data), .tx_pop(tx_pop), .rx_push(rx_push), .rx_data(rx_data),
    .sclk(sclk), .mosi(mosi), .miso(miso), .ss0(ss0), .xfer_done(xfer_done),
    .rx_ready(rx_ready), .burst_done(burst_done));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  logic [31:0] txq[$];
  logic pop_seen = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  // behavioural reference state
  int m_st = 0, m_p = 0, m_g = 0, m_cnt = 1, m_field = 1, m_fsz = 4, m_div = 7;
  bit m_en = 0, m_hold = 0, m_ss = 1, m_done = 0, m_pulse = 0;
  logic [31:0] m_tx = '0, m_rx = '0;
  int rises = 0;
  logic prev_sclk = 1'b0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_st = 0; m_p = 0; m_g = 0; m_cnt = 1; m_field = 1; m_fsz = 4; m_div = 7;
    m_en = 0; m_hold = 0; m_ss = 1; m_done = 0; m_pulse = 0; m_tx = '0; m_rx = '0;
  endtask

  always @(negedge clk) begin
    int hh, nb, idx;
    bit e_sclk, e_mosi, e_pop, e_push;
    if (!rst_n) begin
      model_reset();
    end else begin
      hh = 2 * (m_div + 1);
      nb = (m_fsz == 0) ? 1 : m_fsz;
      e_sclk = (m_st == 1) ? (((m_p / hh) % 2) == 1) : 1'b0;
      idx = nb - 1 - m_p / (2 * hh);
      e_mosi = (m_st == 1 && idx >= 0) ? m_tx[idx] : 1'b0;
      e_pop = (m_st == 0) && m_en && !tx_empty && (m_cnt != 0);
      e_push = (m_st == 1) && (m_p == 2 * nb * hh - 1);
      chk("R3", "sclk", 32'(sclk), 32'(e_sclk));
      chk("R3", "mosi", 32'(mosi), 32'(e_mosi));
      chk(m_hold ? "R5" : "R6", "ss0", 32'(ss0), 32'(m_ss));
      chk("R2", "tx_pop", 32'(tx_pop), 32'(e_pop));
      chk("R4", "rx_push", 32'(rx_push), 32'(e_push));
      chk("R8", "xfer_done", 32'(xfer_done), 32'(m_done));
      chk("R8", "rx_ready", 32'(rx_ready), 32'(m_done));
      chk("R7", "burst_done", 32'(burst_done), 32'(m_pulse));
      if (sclk && !prev_sclk) rises++;
      if (e_push) begin
        chk("R4", "rx_data", rx_data, m_rx);
        chk("R9", "sclk rises per frame", 32'(rises), 32'(nb));
      end
      if (tx_pop) rises = 0;
      prev_sclk = sclk;
      pop_seen = tx_pop;
      // next state
      m_pulse = 0;
      if (m_st == 0) begin
        if (e_pop) begin
          m_tx = tx_data; m_rx = '0; m_ss = 0; m_done = 0; m_st = 1; m_p = 0;
        end
      end else if (m_st == 1) begin
        if ((m_p % (2 * hh)) == hh - 1) m_rx = {m_rx[30:0], miso};
        if (e_push) begin
          m_cnt = m_cnt - 1;
          if (m_cnt == 0) begin
            m_cnt = m_field; m_done = 1; m_pulse = 1; m_ss = 1; m_st = 2; m_g = 0;
          end else if (m_hold) begin
            m_st = 0;
          end else begin
            m_ss = 1; m_st = 2; m_g = 0;
          end
        end else m_p++;
      end else begin
        if (m_g == 2 * hh - 1) m_st = 0; else m_g++;
      end
      if (fsz_we && !m_en && fsz_wdata <= 32) m_fsz = int'(fsz_wdata);
      if (div_we) m_div = int'(div_wdata);
      if (ctrl_we) begin
        if (ctrl_soft_reset) model_reset();
        else begin
          m_en = ctrl_enable; m_hold = ctrl_hold_ss;
          m_field = int'(ctrl_frames); m_cnt = int'(ctrl_frames);
        end
      end
    end
  end

  always @(posedge clk) begin
    #1;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    miso <= lfsr[0];
    #1;
    if (pop_seen && txq.size() > 0) void'(txq.pop_front());
    pop_seen = 1'b0;
    tx_empty = (txq.size() == 0);
    tx_data = (txq.size() > 0) ? txq[0] : 32'h0;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic wr_ctrl(bit en, bit hold, int frames, bit srst);
    @(posedge clk); #1;
    ctrl_we = 1; ctrl_enable = en; ctrl_hold_ss = hold;
    ctrl_frames = 16'(frames); ctrl_soft_reset = srst;
    @(posedge clk); #1;
    ctrl_we = 0; ctrl_soft_reset = 0;
  endtask

  task automatic wr_fsz(int v);
    @(posedge clk); #1; fsz_we = 1; fsz_wdata = 6'(v);
    @(posedge clk); #1; fsz_we = 0;
  endtask

  task automatic wr_div(int v);
    @(posedge clk); #1; div_we = 1; div_wdata = DIVW'(v);
    @(posedge clk); #1; div_we = 0;
  endtask

  task automatic push(logic [31:0] w);
    @(posedge clk); #1; txq.push_back(w);
  endtask

  task automatic wait_quiet();
    int n = 0;
    while ((txq.size() != 0 || m_st != 0) && n < 40000) begin
      @(posedge clk); n++;
    end
    repeat (4) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "reset ss0", 32'(ss0), 32'h1);
    chk("R1", "reset sclk", 32'(sclk), 32'h0);
    chk("R1", "reset pop", 32'(tx_pop), 32'h0);
    chk("R1", "reset done", 32'(xfer_done), 32'h0);

    // default size and divider, one frame, upper bits ignored (R3)
    push(32'hFFFF_FFA5);
    repeat (10) @(posedge clk);
    chk("R2", "no send while disabled", 32'(txq.size()), 32'd1);
    wr_ctrl(1, 0, 1, 0);
    wait_quiet();

    // hold burst of three 8-bit frames, fast clock (R5, R7)
    wr_ctrl(0, 0, 1, 0);
    wr_fsz(8);
    wr_div(0);
    push(32'h0000_00C3); push(32'h0000_005A); push(32'h0000_00F0);
    wr_ctrl(1, 1, 3, 0);
    wait_quiet();

    // hold burst with FIFO running dry mid-burst (R5)
    wr_ctrl(1, 1, 2, 0);
    push(32'h0000_0011);
    repeat (80) @(posedge clk);
    chk("R5", "select held while waiting", 32'(ss0), 32'h0);
    push(32'h0000_0022);
    wait_quiet();

    // pulse mode, bursts of two (R6, R7)
    wr_ctrl(1, 0, 2, 0);
    push(32'h0000_0081); push(32'h0000_0042); push(32'h0000_0024);
    wait_quiet();

    // illegal and enabled size writes ignored (R9)
    wr_fsz(16);
    wr_ctrl(0, 0, 1, 0);
    wr_fsz(40);
    wr_div(1);
    wr_ctrl(1, 0, 1, 0);
    push(32'h0000_0099);
    wait_quiet();

    // full 32-bit frame
    wr_ctrl(0, 0, 1, 0);
    wr_fsz(32);
    wr_ctrl(1, 1, 1, 0);
    push(32'h8123_4567);
    wait_quiet();

    // zero count blocks, control write reloads (R10)
    wr_ctrl(1, 0, 0, 0);
    push(32'h0000_0077);
    repeat (60) @(posedge clk);
    chk("R10", "no frame with zero count", 32'(txq.size()), 32'd1);
    wr_ctrl(1, 0, 1, 0);
    wait_quiet();
    chk("R10", "frame after reload", 32'(txq.size()), 32'd0);

    // soft reset mid-frame (R1)
    wr_ctrl(1, 1, 4, 0);
    push(32'hDEAD_BEEF); push(32'h0000_0001);
    repeat (20) @(posedge clk);
    wr_ctrl(0, 0, 0, 1);
    @(negedge clk);
    chk("R1", "soft reset ss0", 32'(ss0), 32'h1);
    chk("R1", "soft reset sclk", 32'(sclk), 32'h0);
    repeat (30) @(posedge clk);
    chk("R1", "disabled after soft reset", 32'(txq.size()), 32'd1);
    wr_ctrl(1, 0, 1, 0);
    wait_quiet();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule